// File: doc/BRIEF.md
# Endpoint Buffer Window Allocator

This block divides one shared buffer RAM among a small set of endpoints. Each endpoint has a configuration written through a simple write port, made of a bank count and a packet size code. The block holds a base address and a length for every endpoint window. A write that sets or clears an endpoint's bank count reshapes that endpoint's window. Only the window directly above it slides to stay adjacent, and the data in that window is marked lost. Windows further up never move, so gaps and overlaps can arise. These are reported per endpoint as conflicts. A window that starts beyond the end of the RAM is reported as an overflow.

Separate enable and disable strobes keep a per-endpoint enabled flag. These strobes do not touch the allocation. A combinational translation port turns an endpoint index and an offset into an absolute RAM address, and flags offsets that fall outside the window.

Top module: `ebm_window_alloc`

## Requirements
- R1: A configuration write sets the endpoint's length to banks × (8 << code) bytes, with banks in 0..3 and code in 0..7. The allocated flag becomes 1 when banks is nonzero and 0 when banks is zero.
- R2: A written endpoint's base becomes the end (base + length) of the endpoint one index below it. For endpoint 0 the base becomes 0.
- R3: A write with nonzero banks to endpoint x moves endpoint x+1's base to the end of x's new window. If x+1 was allocated, its lost flag is set.
- R4: A write with zero banks to endpoint x gives it length 0, clears its allocated flag, and moves endpoint x+1's base to the end of endpoint x-1. If x+1 was allocated, its lost flag is set.
- R5: A configuration write to endpoint x leaves the base, length and flags of endpoints x+2 and above unchanged.
- R6: A configuration write to an endpoint clears that endpoint's own lost flag.
- R7: An enable strobe sets the addressed endpoint's enabled flag and a disable strobe clears it. Disable wins when both are given. Neither strobe changes any base, length or allocated flag.
- R8: An allocated endpoint's conflict flag is 1 when its end is greater than the base of the nearest higher allocated endpoint, or greater than RAM_BYTES. Otherwise the flag is 0.
- R9: An allocated endpoint's overflow flag is 1 when its base is not less than RAM_BYTES.
- R10: The translation port returns base + offset of the selected endpoint in the same cycle. It raises the error output when the offset is not less than that endpoint's length, or when the index is out of range.
- R11: After reset every base, length, allocated, enabled, lost, conflict and overflow value is zero.
- R12: Every effect of a write or strobe is visible right after the clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ep | input | EPW | Endpoint index for the configuration write |
| cfg_banks | input | 2 | Bank count, 0 frees the window |
| cfg_size | input | 3 | Size code, packet size 8 << code bytes |
| en_stb | input | 1 | Enable strobe |
| dis_stb | input | 1 | Disable strobe |
| stb_ep | input | EPW | Endpoint index for the strobes |
| xl_ep | input | EPW | Endpoint index for translation |
| xl_off | input | OFFW | Offset within the window |
| ep_base | output | N_EP*AW | Base address per endpoint, endpoint i at bits i*AW |
| ep_len | output | N_EP*AW | Window length per endpoint |
| ep_alloc | output | N_EP | Allocated flag per endpoint |
| ep_enabled | output | N_EP | Enabled flag per endpoint |
| ep_lost | output | N_EP | Data lost flag per endpoint |
| ep_conflict | output | N_EP | Overlap or past-end flag per endpoint |
| ep_ovf | output | N_EP | Window starts outside the RAM |
| xl_addr | output | AW | Translated RAM address |
| xl_err | output | 1 | Offset outside the window |

## Verification
Bases, lengths and the allocated, enabled and lost flags are registered. They change at the clock edge that samples the write or strobe, and the conflict and overflow flags follow from them combinationally in that same cycle. The bench drives every input just after a falling edge. It holds the input for one rising edge and checks at the following falling edge, exactly one edge after the stimulus. The translation outputs have no register, so they are checked a short delay after the index and offset change, with no clock edge in between.

// File: rtl/ebm_pkg.sv
// Shared constants and helpers for the endpoint buffer window allocator.
// Assumes bank counts of 0..3 and size codes of 0..7 (8 to 1024 bytes).
package ebm_pkg;
    localparam int BANK_W    = 2;
    localparam int CODE_W    = 3;
    localparam int MIN_BYTES = 8;
    localparam int MAX_BANKS = (1 << BANK_W) - 1;
    localparam int MAX_LEN   = MAX_BANKS * (MIN_BYTES << ((1 << CODE_W) - 1));
endpackage

// File: rtl/ebm_len_calc.sv
// Computes the window length in bytes from a bank count and a size code.
// Assumes AW is wide enough to hold the largest length (MAX_LEN).
module ebm_len_calc #(
    parameter int AW = 16
) (
    input  logic [ebm_pkg::BANK_W-1:0] banks,
    input  logic [ebm_pkg::CODE_W-1:0] code,
    output logic [AW-1:0]              len
);
    // Length is banks times the packet size 8 << code.
    always_comb begin
        len = AW'(banks) * (AW'(ebm_pkg::MIN_BYTES) << code);
    end
endmodule

// File: rtl/ebm_win_check.sv
// Derives per-endpoint conflict and overflow flags from the registered windows.
// Assumes unallocated endpoints are ignored both as subjects and as neighbours.
module ebm_win_check #(
    parameter int N_EP      = 6,
    parameter int RAM_BYTES = 4096,
    parameter int AW        = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_EP-1:0][AW-1:0]  base,
    input  logic [N_EP-1:0][AW-1:0]  len,
    input  logic [N_EP-1:0]          alloc,
    output logic [N_EP-1:0]          conflict,
    output logic [N_EP-1:0]          ovf
);
    localparam logic [AW-1:0] RAM_END = AW'(RAM_BYTES);

    // Compare each allocated window with the RAM end and the nearest allocated window above it.
    always_comb begin
        for (int i = 0; i < N_EP; i++) begin
            logic [AW-1:0] win_end;
            logic [AW-1:0] nb_base;
            logic          nb_hit;
            win_end = base[i] + len[i];
            nb_base = '0;
            nb_hit  = 1'b0;
            for (int j = N_EP - 1; j > i; j--) begin
                if (alloc[j]) begin
                    nb_base = base[j];
                    nb_hit  = 1'b1;
                end
            end
            conflict[i] = alloc[i] && ((win_end > RAM_END) || (nb_hit && win_end > nb_base));
            ovf[i]      = alloc[i] && (base[i] >= RAM_END);
        end
    end

    // An allocated window that starts past the RAM end must also run past it.
    AST_OVF_IMPLIES_CONFLICT: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf & ~conflict) == '0); // R9
endmodule

// File: rtl/ebm_xlat.sv
// Translates an endpoint-relative offset into an absolute RAM address.
// Assumes an index at or above N_EP selects no window and always reports an error.
module ebm_xlat #(
    parameter int N_EP = 6,
    parameter int AW   = 16,
    parameter int EPW  = 3,
    parameter int OFFW = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_EP-1:0][AW-1:0]  base,
    input  logic [N_EP-1:0][AW-1:0]  len,
    input  logic [EPW-1:0]           sel_ep,
    input  logic [OFFW-1:0]          off,
    output logic [AW-1:0]            addr,
    output logic                     err
);
    logic [AW-1:0] sel_base;
    logic [AW-1:0] sel_len;
    logic          sel_ok;

    // Pick the addressed window; an unknown index yields an empty window.
    always_comb begin
        sel_base = '0;
        sel_len  = '0;
        sel_ok   = 1'b0;
        for (int i = 0; i < N_EP; i++) begin
            if (int'(sel_ep) == i) begin
                sel_base = base[i];
                sel_len  = len[i];
                sel_ok   = 1'b1;
            end
        end
    end

    // Form the address and range-check the offset.
    always_comb begin
        addr = sel_base + AW'(off);
        err  = !sel_ok || (AW'(off) >= sel_len);
    end

    // An accepted offset always maps strictly inside the selected window.
    AST_XLAT_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        !err |-> (addr >= sel_base && addr < sel_base + sel_len)); // R10
endmodule

// File: rtl/ebm_window_alloc.sv
// Top of the endpoint buffer window allocator. It holds base, length and status
// per endpoint, applies a configuration write in one clock, and slides only the
// next-higher window. Assumes one configuration write per cycle; writes to an
// index at or above N_EP are ignored.
module ebm_window_alloc #(
    parameter int  N_EP      = 6,
    parameter int  RAM_BYTES = 4096,
    localparam int EPW       = (N_EP > 1) ? $clog2(N_EP) : 1,
    localparam int AW        = $clog2(N_EP * ebm_pkg::MAX_LEN + 1) + 1,
    localparam int OFFW      = $clog2(ebm_pkg::MAX_LEN)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_we,
    input  logic [EPW-1:0]            cfg_ep,
    input  logic [ebm_pkg::BANK_W-1:0] cfg_banks,
    input  logic [ebm_pkg::CODE_W-1:0] cfg_size,
    input  logic                      en_stb,
    input  logic                      dis_stb,
    input  logic [EPW-1:0]            stb_ep,
    input  logic [EPW-1:0]            xl_ep,
    input  logic [OFFW-1:0]           xl_off,
    output logic [N_EP*AW-1:0]        ep_base,
    output logic [N_EP*AW-1:0]        ep_len,
    output logic [N_EP-1:0]           ep_alloc,
    output logic [N_EP-1:0]           ep_enabled,
    output logic [N_EP-1:0]           ep_lost,
    output logic [N_EP-1:0]           ep_conflict,
    output logic [N_EP-1:0]           ep_ovf,
    output logic [AW-1:0]             xl_addr,
    output logic                      xl_err
);
    logic [N_EP-1:0][AW-1:0] base_q;
    logic [N_EP-1:0][AW-1:0] len_q;
    logic [N_EP-1:0]         alloc_q;
    logic [N_EP-1:0]         en_q;
    logic [N_EP-1:0]         lost_q;
    logic [AW-1:0]           new_len;
    logic [AW-1:0]           prev_end;

    ebm_len_calc #(.AW(AW)) u_len (
        .banks (cfg_banks),
        .code  (cfg_size),
        .len   (new_len)
    );

    // End of the window just below the written endpoint (0 for endpoint 0).
    always_comb begin
        prev_end = '0;
        for (int i = 1; i < N_EP; i++) begin
            if (int'(cfg_ep) == i) begin
                prev_end = base_q[i-1] + len_q[i-1];
            end
        end
    end

    // Apply a configuration write to the written window and its upper neighbour.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            len_q   <= '0;
            alloc_q <= '0;
            lost_q  <= '0;
        end else if (cfg_we) begin
            for (int i = 0; i < N_EP; i++) begin
                if (int'(cfg_ep) == i) begin
                    base_q[i]  <= prev_end;
                    len_q[i]   <= new_len;
                    alloc_q[i] <= (cfg_banks != '0);
                    lost_q[i]  <= 1'b0;
                end else if (int'(cfg_ep) + 1 == i) begin
                    base_q[i]  <= prev_end + new_len;
                    lost_q[i]  <= lost_q[i] | alloc_q[i];
                end
            end
        end
    end

    // Track the enabled flags; disable takes priority over enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else begin
            for (int i = 0; i < N_EP; i++) begin
                if (int'(stb_ep) == i) begin
                    if (dis_stb)     en_q[i] <= 1'b0;
                    else if (en_stb) en_q[i] <= 1'b1;
                end
            end
        end
    end

    ebm_win_check #(.N_EP(N_EP), .RAM_BYTES(RAM_BYTES), .AW(AW)) u_chk (
        .clk      (clk),
        .rst_n    (rst_n),
        .base     (base_q),
        .len      (len_q),
        .alloc    (alloc_q),
        .conflict (ep_conflict),
        .ovf      (ep_ovf)
    );

    ebm_xlat #(.N_EP(N_EP), .AW(AW), .EPW(EPW), .OFFW(OFFW)) u_xlat (
        .clk    (clk),
        .rst_n  (rst_n),
        .base   (base_q),
        .len    (len_q),
        .sel_ep (xl_ep),
        .off    (xl_off),
        .addr   (xl_addr),
        .err    (xl_err)
    );

    // Drive the flat status outputs from the registers.
    always_comb begin
        ep_base    = base_q;
        ep_len     = len_q;
        ep_alloc   = alloc_q;
        ep_enabled = en_q;
        ep_lost    = lost_q;
    end

    // Strobes alone never reshape the allocation.
    AST_STROBE_KEEPS_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_we && (en_stb || dis_stb)) |=> $stable(alloc_q)); // R7

    for (genvar g = 0; g < N_EP; g++) begin : g_ast
        // The written endpoint's lost flag is cleared.
        AST_LOST_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_we && int'(cfg_ep) == g) |=> !lost_q[g]); // R6
        // Windows two or more above the written one never move.
        AST_FAR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_we && int'(cfg_ep) + 1 < g) |=> ($stable(base_q[g]) && $stable(len_q[g]))); // R5
        if (g + 1 < N_EP) begin : g_up
            // The neighbour above ends up adjacent to the written window.
            AST_NEXT_ADJACENT: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg_we && int'(cfg_ep) == g) |=> (base_q[g+1] == base_q[g] + len_q[g])); // R3
        end
        if (g > 0) begin : g_dn
            // A written window starts at the end of the one below.
            AST_NEW_BASE: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg_we && int'(cfg_ep) == g) |=> (base_q[g] == $past(base_q[g-1] + len_q[g-1]))); // R2
        end
    end
endmodule

// File: tb/sim_ebm_window_alloc.sv
// Directed bench for the endpoint buffer window allocator.
module sim_ebm_window_alloc;
    localparam int N_EP = 6;
    localparam int RAM  = 4096;
    localparam int EPW  = $clog2(N_EP);
    localparam int AW   = $clog2(N_EP * ebm_pkg::MAX_LEN + 1) + 1;
    localparam int OFFW = $clog2(ebm_pkg::MAX_LEN);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [EPW-1:0] cfg_ep = '0;
    logic [1:0] cfg_banks = '0;
    logic [2:0] cfg_size = '0;
    logic en_stb = 1'b0;
    logic dis_stb = 1'b0;
    logic [EPW-1:0] stb_ep = '0;
    logic [EPW-1:0] xl_ep = '0;
    logic [OFFW-1:0] xl_off = '0;
    logic [N_EP*AW-1:0] ep_base, ep_len;
    logic [N_EP-1:0] ep_alloc, ep_enabled, ep_lost, ep_conflict, ep_ovf;
    logic [AW-1:0] xl_addr;
    logic xl_err;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    ebm_window_alloc #(.N_EP(N_EP), .RAM_BYTES(RAM)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ep(cfg_ep),
        .cfg_banks(cfg_banks), .cfg_size(cfg_size), .en_stb(en_stb),
        .dis_stb(dis_stb), .stb_ep(stb_ep), .xl_ep(xl_ep), .xl_off(xl_off),
        .ep_base(ep_base), .ep_len(ep_len), .ep_alloc(ep_alloc),
        .ep_enabled(ep_enabled), .ep_lost(ep_lost), .ep_conflict(ep_conflict),
        .ep_ovf(ep_ovf), .xl_addr(xl_addr), .xl_err(xl_err)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Check every output field of one endpoint.
    task automatic chk_ep(input string tag, input int i, input int b, input int l,
                          input int a, input int lo, input int cf, input int ov);
        chk({tag, " base"}, int'(ep_base[i*AW +: AW]), b);
        chk({tag, " len"}, int'(ep_len[i*AW +: AW]), l);
        chk({tag, " alloc"}, int'(ep_alloc[i]), a);
        chk({tag, " lost"}, int'(ep_lost[i]), lo);
        chk({tag, " conflict"}, int'(ep_conflict[i]), cf);
        chk({tag, " ovf"}, int'(ep_ovf[i]), ov);
    endtask

    // One configuration write, held for one rising edge; returns at the next falling edge.
    task automatic do_cfg(input int ep, input int banks, input int code);
        @(negedge clk);
        cfg_we = 1'b1; cfg_ep = EPW'(ep); cfg_banks = 2'(banks); cfg_size = 3'(code);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic do_stb(input int ep, input bit en, input bit dis);
        @(negedge clk);
        en_stb = en; dis_stb = dis; stb_ep = EPW'(ep);
        @(negedge clk);
        en_stb = 1'b0; dis_stb = 1'b0;
    endtask

    task automatic do_xl(input string tag, input int ep, input int off, input int a, input int e);
        xl_ep = EPW'(ep); xl_off = OFFW'(off);
        #1;
        if (e == 0) chk({tag, " addr"}, int'(xl_addr), a);
        chk({tag, " err"}, int'(xl_err), e);
    endtask

    task automatic t_reset;
        for (int i = 0; i < N_EP; i++) chk_ep("R11 reset", i, 0, 0, 0, 0, 0, 0);
        chk("R11 reset enabled", int'(ep_enabled), 0);
    endtask

    task automatic t_fill;
        for (int i = 0; i < N_EP; i++) do_stb(i, 1'b1, 1'b0);
        chk("R7 enable all", int'(ep_enabled), 63);
        do_cfg(0, 1, 3);
        chk_ep("R1 R12 ep0", 0, 0, 64, 1, 0, 0, 0);
        chk("R3 ep1 slid unalloc", int'(ep_base[1*AW +: AW]), 64);
        chk("R3 ep1 not lost", int'(ep_lost[1]), 0);
        do_cfg(1, 2, 3);
        do_cfg(2, 1, 4);
        do_cfg(3, 1, 4);
        do_cfg(4, 1, 5);
        do_cfg(5, 1, 3);
        chk_ep("R2 ep1", 1, 64, 128, 1, 0, 0, 0);
        chk_ep("R2 ep3", 3, 320, 128, 1, 0, 0, 0);
        chk_ep("R2 ep4", 4, 448, 256, 1, 0, 0, 0);
        chk_ep("R2 ep5", 5, 704, 64, 1, 0, 0, 0);
    endtask

    task automatic t_disable;
        do_stb(3, 1'b1, 1'b1);
        chk("R7 disable wins", int'(ep_enabled[3]), 0);
        chk_ep("R7 ep3 kept", 3, 320, 128, 1, 0, 0, 0);
    endtask

    task automatic t_free_realloc;
        do_cfg(3, 0, 4);
        chk_ep("R4 ep3 freed", 3, 320, 0, 0, 0, 0, 0);
        chk_ep("R4 ep4 slid down", 4, 320, 256, 1, 1, 0, 0);
        chk_ep("R5 ep5 fixed", 5, 704, 64, 1, 0, 0, 0);
        do_xl("R10 freed window", 3, 0, 0, 1);
        do_cfg(3, 3, 5);
        chk_ep("R1 ep3 larger", 3, 320, 768, 1, 0, 0, 0);
        chk_ep("R8 ep4 overlaps ep5", 4, 1088, 256, 1, 1, 1, 0);
        chk_ep("R5 ep5 still fixed", 5, 704, 64, 1, 0, 0, 0);
        do_cfg(4, 1, 5);
        chk_ep("R6 ep4 rewritten", 4, 1088, 256, 1, 0, 0, 0);
        chk_ep("R3 ep5 slid up", 5, 1344, 64, 1, 1, 0, 0);
    endtask

    task automatic t_overflow;
        do_cfg(5, 3, 7);
        chk_ep("R8 ep5 past end", 5, 1344, 3072, 1, 0, 1, 0);
        do_cfg(4, 3, 7);
        chk_ep("R8 ep4 past end", 4, 1088, 3072, 1, 0, 1, 0);
        chk_ep("R9 ep5 overflow", 5, 4160, 3072, 1, 1, 1, 1);
    endtask

    task automatic t_xlat;
        do_xl("R10 ep2 first", 2, 0, 192, 0);
        do_xl("R10 ep2 last", 2, 127, 319, 0);
        do_xl("R10 ep2 edge", 2, 128, 0, 1);
        do_xl("R10 bad index", 7, 0, 0, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fill();
        t_xlat();
        t_disable();
        t_free_realloc();
        t_overflow();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule